// File: doc/BRIEF.md
# Target Address Capture and Verify

This block sits between a host processor and the 16-bit address bus of a unit under test. While the target-on (test mode) input is high, the host address passes straight onto the target bus. While it is low, the host is cut off and the target bus is parked at 0x0000, so nothing on the target side can be selected by accident.

The block also watches the levels that actually appear on the target address lines. The lines pass through a two-flop synchronizer. On each rising edge of the qualified strobe (target-on AND phase-two enable), the block captures those levels into two byte-wide registers and keeps a copy of the intended host address. After the cycle, the host reads the captured bytes through two decoded read addresses. A one-cycle compare strobe raises a sticky address-error flag when the captured value differs from the intended one.

A small sequencer tracks each capture. ST_PARK is the idle state with target-on low. ST_DRIVE is the idle state with target-on high. ST_SYNC1 and ST_SYNC2 are the two cycles during which a sample moves through the synchronizer. Transitions:
- A qualified rise in ST_PARK or ST_DRIVE moves to ST_SYNC1 and latches the intended address.
- Without a rise, ST_PARK moves to ST_DRIVE when target-on goes high, and ST_DRIVE moves to ST_PARK when it goes low.
- ST_SYNC1 always moves to ST_SYNC2.
- ST_SYNC2 loads the capture registers and then moves to ST_DRIVE or ST_PARK, following target-on.

Top module: `tgt_addr_probe`

## Requirements
- R1: While `tgt_on` is 1, `tgt_addr_out` equals `host_addr` in the same cycle.
- R2: While `tgt_on` is 0, `tgt_addr_out` is 0x0000.
- R3: The capture condition is a rising edge of (`tgt_on` AND `ph2_en`) seen in cycle c. Bit i of the capture equals the level of `tgt_sense[i]` in cycle c, and the new value becomes readable in the third cycle after c. A `ph2_en` pulse while `tgt_on` is 0 captures nothing.
- R4: In the two cycles after an accepted rise, a new rise is ignored. The capture registers keep their value until the next accepted capture, including after `tgt_on` falls.
- R5: With `host_rd`=1, address 0x3000 returns capture bits 7..0 and address 0x6000 returns bits 15..8 on `host_dout`, with `host_doe`=1.
- R6: With `host_rd`=0, or at any other address, `host_doe` is 0 and `host_dout` is 0x00.
- R7: When `cmp_stb` is 1 at a clock edge, `addr_err` becomes 1 if the 16-bit capture differs from the host address recorded at that capture's rise. On a match it is left unchanged.
- R8: `addr_err` is sticky. It is cleared by `host_wr`=1 at address 0x3000 or 0x6000. If a mismatching compare and a clear fall on the same edge, the flag is set.
- R9: After reset, `addr_err` is 0, both capture bytes read as 0x00 and the sequencer is in ST_PARK.
- R10: Holding `ph2_en` high for many cycles triggers only one capture. Only the rising edge of the qualified strobe counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_on | input | 1 | Test mode: host drives the target bus |
| ph2_en | input | 1 | Phase-two enable, qualifies capture |
| host_addr | input | 16 | Host address bus |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (clears error at decode addresses) |
| cmp_stb | input | 1 | One-cycle compare strobe |
| tgt_sense | input | 16 | Levels observed on the target address lines |
| tgt_addr_out | output | 16 | Address driven onto the target bus |
| host_dout | output | 8 | Read-back data byte |
| host_doe | output | 1 | Read-back data enable (bus driven when 1) |
| addr_err | output | 1 | Sticky address-error flag |

## Verification
The bench aims at the synchronizer window. A design that samples the lines one cycle late or early would read back a byte belonging to the neighbouring cycle, so the sense lines change right after each strobe. Back-to-back strobes and a `ph2_en` held high look for a design that re-captures on a level, or during a capture already in flight, and so overwrites the first sample. A strobe without target-on must leave the captured bytes untouched. A clear and a failing compare on the same edge tell apart a design that gives the clear priority. Unmapped and non-read accesses check that the data enable stays low.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int TAP_AW = 16;
    localparam int TAP_BW = 8;
    localparam int TAP_NB = TAP_AW / TAP_BW;
    localparam int TAP_SYNC = 2;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_SYNC1 = 2'd2,
        ST_SYNC2 = 2'd3
    } tap_state_e;
endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/tap_seq.sv
module tap_seq
    import tap_pkg::*;
#(
    parameter int AW = TAP_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tgt_on,
    input  logic          ph2_en,
    input  logic [AW-1:0] host_addr,
    output logic [AW-1:0] bus_out,
    output logic          cap_en,
    output logic [AW-1:0] exp_addr
);
    tap_state_e state_q, state_d;
    logic       qual, qual_q, qual_rise, load_exp;

    assign qual      = tgt_on & ph2_en;
    assign qual_rise = qual & ~qual_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PARK;
            qual_q   <= 1'b0;
            exp_addr <= '0;
        end else begin
            state_q <= state_d;
            qual_q  <= qual;
            if (load_exp) exp_addr <= host_addr;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK: begin
                if (qual_rise)   state_d = ST_SYNC1;
                else if (tgt_on) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (qual_rise)    state_d = ST_SYNC1;
                else if (!tgt_on) state_d = ST_PARK;
            end
            ST_SYNC1: state_d = ST_SYNC2;
            ST_SYNC2: state_d = tgt_on ? ST_DRIVE : ST_PARK;
            default:  state_d = ST_PARK;
        endcase
    end

    // outputs
    always_comb begin
        cap_en   = (state_q == ST_SYNC2);
        load_exp = qual_rise && ((state_q == ST_PARK) || (state_q == ST_DRIVE));
        bus_out  = tgt_on ? host_addr : '0;
    end

    // R4: a sample always spends exactly one cycle in each sync state
    a_r4_sync_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC2) |-> ($past(state_q) == ST_SYNC1));
    a_r4_sync_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC1) |=> (state_q == ST_SYNC2));
    // R10: the sequencer only leaves idle after a fresh qualified edge
    a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRIVE) && qual_q) |=> (state_q != ST_SYNC1));
endmodule

// File: rtl/tap_capture.sv
module tap_capture
    import tap_pkg::*;
#(
    parameter int AW = TAP_AW,
    parameter int BW = TAP_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] sense_sync,
    input  logic [AW-1:0] exp_addr,
    input  logic          cmp_stb,
    input  logic          clr_req,
    output logic [AW-1:0] cap_q,
    output logic          err_q
);
    localparam int NB = AW / BW;

    logic [AW-1:0] exp_q;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)      cap_q[b*BW +: BW] <= '0;
            else if (cap_en) cap_q[b*BW +: BW] <= sense_sync[b*BW +: BW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      exp_q <= '0;
        else if (cap_en) exp_q <= exp_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (cmp_stb && (cap_q != exp_q)) err_q <= 1'b1;
        else if (clr_req)                    err_q <= 1'b0;
    end

    // R4: captured bytes change only on a capture enable
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_q));
    // R8: the flag stays set until a clear request
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_req) |=> err_q);
    // R7: a flag rise needs a compare strobe
    a_r7_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && !cmp_stb) |=> !err_q);
endmodule

// File: rtl/tap_readback.sv
module tap_readback
    import tap_pkg::*;
#(
    parameter int            AW     = TAP_AW,
    parameter int            BW     = TAP_BW,
    parameter logic [AW-1:0] LO_SEL = 16'h3000,
    parameter logic [AW-1:0] HI_SEL = 16'h6000
) (
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [AW-1:0] cap_q,
    output logic [BW-1:0] host_dout,
    output logic          host_doe,
    output logic          clr_req
);
    logic hit_lo, hit_hi;

    always_comb begin
        hit_lo   = (host_addr == LO_SEL);
        hit_hi   = (host_addr == HI_SEL);
        host_doe = host_rd && (hit_lo || hit_hi);
        clr_req  = host_wr && (hit_lo || hit_hi);
        if (host_rd && hit_lo)      host_dout = cap_q[BW-1:0];
        else if (host_rd && hit_hi) host_dout = cap_q[2*BW-1:BW];
        else                        host_dout = '0;
    end
endmodule

// File: rtl/tgt_addr_probe.sv
module tgt_addr_probe
    import tap_pkg::*;
#(
    parameter logic [TAP_AW-1:0] LO_SEL = 16'h3000,
    parameter logic [TAP_AW-1:0] HI_SEL = 16'h6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_on,
    input  logic              ph2_en,
    input  logic [TAP_AW-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              cmp_stb,
    input  logic [TAP_AW-1:0] tgt_sense,
    output logic [TAP_AW-1:0] tgt_addr_out,
    output logic [TAP_BW-1:0] host_dout,
    output logic              host_doe,
    output logic              addr_err
);
    logic [TAP_AW-1:0] sense_sync, exp_addr, cap_q;
    logic              cap_en, clr_req;

    tap_sync #(.W(TAP_AW), .STAGES(TAP_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(tgt_sense), .d_out(sense_sync)
    );

    tap_seq #(.AW(TAP_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tgt_on(tgt_on), .ph2_en(ph2_en),
        .host_addr(host_addr), .bus_out(tgt_addr_out),
        .cap_en(cap_en), .exp_addr(exp_addr)
    );

    tap_capture #(.AW(TAP_AW), .BW(TAP_BW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sense_sync(sense_sync),
        .exp_addr(exp_addr), .cmp_stb(cmp_stb), .clr_req(clr_req),
        .cap_q(cap_q), .err_q(addr_err)
    );

    tap_readback #(.AW(TAP_AW), .BW(TAP_BW), .LO_SEL(LO_SEL), .HI_SEL(HI_SEL)) u_rb (
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .cap_q(cap_q), .host_dout(host_dout), .host_doe(host_doe),
        .clr_req(clr_req)
    );

    a_r2_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_on |-> (tgt_addr_out == '0));
    a_r1_driven: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_on |-> (tgt_addr_out == host_addr));
    a_r6_decode: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> (host_rd && ((host_addr == LO_SEL) || (host_addr == HI_SEL))));
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_doe |-> (host_dout == '0));
endmodule

// File: tb/tgt_addr_probe_tb.sv
module tgt_addr_probe_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_on = 1'b0, ph2_en = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0, cmp_stb = 1'b0;
    logic [15:0] tgt_sense = '0;
    logic [15:0] tgt_addr_out;
    logic [7:0]  host_dout;
    logic        host_doe, addr_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model state
    int unsigned m_cap = 0, m_exp = 0, m_pend_s = 0, m_pend_a = 0;
    int          m_busy = 0;
    bit          m_qd = 0, m_err = 0;

    always #4 clk = ~clk;

    tgt_addr_probe u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_on(tgt_on), .ph2_en(ph2_en),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .cmp_stb(cmp_stb), .tgt_sense(tgt_sense), .tgt_addr_out(tgt_addr_out),
        .host_dout(host_dout), .host_doe(host_doe), .addr_err(addr_err)
    );

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit q, rise, hit;
        if (!rst_n) begin
            m_cap = 0; m_exp = 0; m_busy = 0; m_qd = 0; m_err = 0;
            return;
        end
        q    = tgt_on & ph2_en;
        rise = q & !m_qd;
        hit  = (host_addr == 16'h3000) || (host_addr == 16'h6000);
        if (cmp_stb && m_cap != m_exp) m_err = 1;
        else if (host_wr && hit)       m_err = 0;
        if (m_busy == 2) begin
            m_cap = m_pend_s; m_exp = m_pend_a; m_busy = 0;
        end else if (m_busy == 1) begin
            m_busy = 2;
        end else if (rise) begin
            m_pend_s = tgt_sense; m_pend_a = host_addr; m_busy = 1;
        end
        m_qd = q;
    endtask

    task automatic compare();
        int unsigned ed, eo;
        bit ee;
        chk(tgt_on ? "R1 bus" : "R2 bus", tgt_addr_out, tgt_on ? host_addr : 0);
        ee = host_rd && (host_addr == 16'h3000 || host_addr == 16'h6000);
        ed = !host_rd ? 0 : (host_addr == 16'h3000) ? (m_cap & 8'hFF) :
             (host_addr == 16'h6000) ? ((m_cap >> 8) & 8'hFF) : 0;
        eo = ee;
        chk(ee ? "R5 doe" : "R6 doe", host_doe, eo);
        chk(ee ? "R5 dout" : "R6 dout", host_dout, ed);
        chk("R7 err", addr_err, m_err);
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            #2;
            compare();
        end
    endtask

    task automatic expect_rd(string tag, logic [15:0] a, int unsigned exp);
        host_addr = a; host_rd = 1'b1;
        #1;
        chk(tag, {host_doe, host_dout}, {1'b1, exp[7:0]});
        cyc();
        host_rd = 1'b0;
    endtask

    task automatic strobe(logic [15:0] a, logic [15:0] s);
        host_addr = a; tgt_sense = s; ph2_en = 1'b1;
        cyc();
        ph2_en = 1'b0; tgt_sense = ~s;
        cyc(4);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R9 reset state
        chk("R9 err", addr_err, 0);
        expect_rd("R9 lo", 16'h3000, 8'h00);
        expect_rd("R9 hi", 16'h6000, 8'h00);

        // R3 matching capture, R4 held after target-on drops
        tgt_on = 1'b1; cyc();
        strobe(16'h1234, 16'h1234);
        tgt_on = 1'b0; cyc(2);
        expect_rd("R3 lo", 16'h3000, 8'h34);
        expect_rd("R4 hi", 16'h6000, 8'h12);
        cmp_stb = 1'b1; cyc(); cmp_stb = 1'b0;
        chk("R7 match", addr_err, 0);

        // R7 mismatch, R8 sticky/clear/priority
        tgt_on = 1'b1; cyc();
        strobe(16'hA5C3, 16'hA5C7);
        cmp_stb = 1'b1; cyc(); cmp_stb = 1'b0;
        chk("R7 mismatch", addr_err, 1);
        cyc(2);
        chk("R8 sticky", addr_err, 1);
        host_addr = 16'h3000; host_wr = 1'b1; cyc(); host_wr = 1'b0;
        chk("R8 clear", addr_err, 0);
        host_addr = 16'h6000; host_wr = 1'b1; cmp_stb = 1'b1; cyc();
        host_wr = 1'b0; cmp_stb = 1'b0;
        chk("R8 priority", addr_err, 1);
        host_addr = 16'h6000; host_wr = 1'b1; cyc(); host_wr = 1'b0;

        // R4 second rise while capture in flight is ignored
        host_addr = 16'h1111; tgt_sense = 16'h1111; ph2_en = 1'b1; cyc();
        ph2_en = 1'b0; tgt_sense = 16'h2222; cyc();
        ph2_en = 1'b1; host_addr = 16'h2222; cyc();
        ph2_en = 1'b0; cyc(4);
        expect_rd("R4 ignored lo", 16'h3000, 8'h11);
        expect_rd("R4 ignored hi", 16'h6000, 8'h11);

        // R10 held phase-two: one capture only
        host_addr = 16'h00FF; tgt_sense = 16'h00FF; ph2_en = 1'b1; cyc();
        tgt_sense = 16'hFF00; cyc(8);
        ph2_en = 1'b0; cyc(2);
        expect_rd("R10 lo", 16'h3000, 8'hFF);
        expect_rd("R10 hi", 16'h6000, 8'h00);

        // R3 no capture without target-on
        tgt_on = 1'b0; cyc();
        strobe(16'hBEEF, 16'hBEEF);
        expect_rd("R3 off lo", 16'h3000, 8'hFF);
        expect_rd("R3 off hi", 16'h6000, 8'h00);

        // R6 unmapped / no read
        host_addr = 16'h3001; host_rd = 1'b1; #1;
        chk("R6 unmapped", host_doe, 0);
        cyc(); host_rd = 1'b0;
        host_addr = 16'h3000; #1;
        chk("R6 no read", host_doe, 0);
        cyc();

        // R1 driven bus with a few patterns
        tgt_on = 1'b1;
        for (int k = 0; k < 4; k++) begin
            host_addr = 16'h5A5A ^ (16'h1 << (k * 4)); #1;
            chk("R1 drive", tgt_addr_out, host_addr);
            cyc();
        end
        tgt_on = 1'b0; #1;
        chk("R2 park", tgt_addr_out, 0);
        cyc();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule